// File: doc/BRIEF.md
# BCD Calendar Clock with Holding Registers

This block keeps time of day and calendar date in packed BCD, from seconds up to the century. A prescaler divides a 32,768 Hz reference, delivered as a single-cycle enable on `ref_tick`, down to one pulse per second. Each pulse advances a chain of live counters. The chain handles 24-hour time, a day-of-week count, months of 28, 29, 30 and 31 days, and leap years.

The host never touches the live counters. It sees nine bytes at the top of a byte-wide address space: eight holding bytes and one control byte. The holding bytes are copied from the live counters once per second. Two control bits change that behaviour:

- The freeze bit stops the copy, so that a multi-byte read is consistent.
- The set bit also stops the copy. While it is set, the host writes a new time into the holding bytes. Clearing it transfers those bytes into the live counters.

Access uses a simple synchronous bus. A write takes effect at the clock edge where it is presented. Read data appears on `bus_rdata` after the clock edge where the read is presented, and holds until the next read.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the holding bytes read century 0x20, year 0x00, month 0x01, date 0x01, day 0x01, hour 0x00, minute 0x00 and second 0x00. The control byte reads 0x00.
- R2: The live time advances by one second at every DIV_COUNT-th clock with `ref_tick` high, and it does not advance while `ref_tick` is low. A load from the host restarts the prescaler, so the first second after a load comes DIV_COUNT reference pulses later.
- R3: The fields count in packed BCD. Seconds and minutes wrap from 0x59 to 0x00 with a carry. Hours wrap from 0x23 to 0x00 with a carry into the day.
- R4: The day-of-week field counts 0x01 to 0x07. At midnight it returns from 0x07 to 0x01.
- R5: At midnight the date moves on from the month's last day to 0x01 and carries into the month. The last day is 31, 30 for months 0x04/0x06/0x09/0x11, and for 0x02 it is 29 when the year is divisible by 4 and 28 otherwise.
- R6: The month wraps from 0x12 to 0x01 with a carry into the year. The year wraps from 0x99 to 0x00 with a carry into the century. The century wraps from 0x99 to 0x00.
- R7: The byte addresses are 0x7FFF second, 0x7FFE minute, 0x7FFD hour, 0x7FFC day-of-week, 0x7FFB date, 0x7FFA month, 0x7FF9 year, 0x7FF1 century and 0x7FF8 control. With both control bits clear, the holding bytes show the advanced time at the edge after each second pulse.
- R8: While control bit 6 (freeze) is set, the holding bytes are not refreshed, and the live counters keep running. After it is cleared, the next refresh shows the live time.
- R9: While control bit 7 (set) is set, the holding bytes are not refreshed and accept host writes. Writing the control byte with bit 7 clear while it was set loads all eight holding bytes into the live counters.
- R10: A load that falls in the same cycle as a second pulse wins. The counters take the host values and that second is dropped.
- R11: A host write to a holding byte in the same cycle as a refresh wins for that byte. The other bytes take the refreshed time.
- R12: Reads of 0x7FF0, of 0x7FF2 to 0x7FF7 and of any address outside 0x7FF0 to 0x7FFF return 0x00, and writes there change nothing. The control byte reads its two bits in positions 7 and 6, with zeros below them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle enable at the 32,768 Hz reference rate |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |

## Verification
Two functions can hit the same edge: a host write to a holding byte, and the once-per-second refresh of all holding bytes. A host load and a second pulse can also coincide.

The bench counts cycles from a load, which restarts the prescaler, so the phase of every later pulse is known. It then lands a write of the seconds byte exactly on the refresh edge, and lands a load exactly on a pulse edge.

For the first case, the bench judges the outcome by reading back the host-written second next to a minute that has already rolled over. For the second, it reads the time one pulse later and expects it to be exactly one second past the loaded value.

// File: rtl/rtc_pkg.sv
// Package rtc_pkg
// Shared time record, reset value and BCD helper functions for the calendar
// clock. Assumes all time fields hold valid packed BCD.
package rtc_pkg;

    // Byte slot order inside the record: slot 0 is second, slot 7 is century.
    typedef struct packed {
        logic [7:0] century;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } rtc_time_t;

    localparam int SLOTS = 8;
    localparam logic [8*SLOTS-1:0] RTC_RESET_BITS = 64'h20_00_01_01_01_00_00_00;

    // Low address nibble of each holding slot; century sits apart from the rest.
    function automatic logic [3:0] slot_nibble(input int idx);
        return (idx == SLOTS - 1) ? 4'h1 : 4'(15 - idx);
    endfunction

    // Increment a BCD byte, returning 'first' when 'top' is passed.
    function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] top,
                                            input logic [7:0] first);
        if (v == top)
            return first;
        else if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    // Divisible-by-4 test on a BCD year: even tens need 0/4/8, odd tens need 2/6.
    function automatic logic bcd_leap(input logic [7:0] yr);
        if (!yr[4])
            return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
        else
            return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    endfunction

    // Last date of a BCD month, in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] mon,
                                              input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
// Module rtc_sec_divider
// Counts reference enable pulses and emits a one-cycle pulse on every
// DIV_COUNT-th one. A restart clears the count. Assumes DIV_COUNT >= 2.
module rtc_sec_divider #(
    parameter int DIV_COUNT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic restart_i,
    output logic pulse_o
);
    localparam int CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

    logic [CW-1:0] cnt_q;

    // Prescaler count: cleared by reset or restart, stepped by each reference pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            cnt_q <= '0;
        else if (ref_tick_i)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign pulse_o = ref_tick_i && (cnt_q == LAST);

    // R2: a second pulse never lasts two cycles.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R2: without reference pulses or a restart, the count holds.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick_i && !restart_i) |=> $stable(cnt_q));
    // R2: a restart leaves the prescaler at zero.
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_time_core.sv
// Module rtc_time_core
// Live seconds-to-century counters in packed BCD. They advance once per tick
// with month-length and leap-year handling, and take a host value on load.
// Load has priority over tick. Assumes loaded values are valid BCD.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t time_o
);
    rtc_time_t time_q;
    rtc_time_t time_nx;
    logic c_sec, c_min, c_hour, c_date, c_mon, c_year;
    logic [7:0] last_day;

    // Carry chain and next-second value of every field.
    always_comb begin
        last_day = month_last(time_q.month, time_q.year);
        c_sec    = (time_q.second == 8'h59);
        c_min    = c_sec  && (time_q.minute == 8'h59);
        c_hour   = c_min  && (time_q.hour == 8'h23);
        c_date   = c_hour && (time_q.date == last_day);
        c_mon    = c_date && (time_q.month == 8'h12);
        c_year   = c_mon  && (time_q.year == 8'h99);

        time_nx         = time_q;
        time_nx.second  = bcd_step(time_q.second, 8'h59, 8'h00);
        if (c_sec)  time_nx.minute  = bcd_step(time_q.minute, 8'h59, 8'h00);
        if (c_min)  time_nx.hour    = bcd_step(time_q.hour, 8'h23, 8'h00);
        if (c_hour) time_nx.dow     = bcd_step(time_q.dow, 8'h07, 8'h01);
        if (c_hour) time_nx.date    = bcd_step(time_q.date, last_day, 8'h01);
        if (c_date) time_nx.month   = bcd_step(time_q.month, 8'h12, 8'h01);
        if (c_mon)  time_nx.year    = bcd_step(time_q.year, 8'h99, 8'h00);
        if (c_year) time_nx.century = bcd_step(time_q.century, 8'h99, 8'h00);
    end

    // Live counter register: reset, host load first, then one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            time_q <= rtc_time_t'(RTC_RESET_BITS);
        else if (load_i)
            time_q <= load_val_i;
        else if (tick_i)
            time_q <= time_nx;
    end

    assign time_o = time_q;

    // R2: with neither a tick nor a load, the live time holds.
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(time_q));
    // R10: a load always lands exactly, even in a tick cycle.
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (time_q == $past(load_val_i)));
    // R3: every tick changes the seconds field.
    a_r3_second_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (time_q.second != $past(time_q.second)));
    // R4: day-of-week changes only together with a zero hour after a tick.
    a_r4_dow_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && (time_q.dow != time_nx.dow)) |=> (time_q.hour == 8'h00));
endmodule

// File: rtl/rtc_host_regs.sv
// Module rtc_host_regs
// Host-visible holding bytes and the control byte. It decodes the bus,
// refreshes the holding bytes one cycle after each second pulse unless a
// control bit blocks it, and issues the load pulse when the set bit is cleared.
// Assumes one bus access per cycle.
module rtc_host_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              refresh_i,
    input  rtc_time_t         live_i,
    output rtc_time_t         hold_o,
    output logic              load_o
);
    localparam int CTRL_NIB = 8;

    logic                  in_win;
    logic [3:0]            nib;
    logic                  wr_en;
    logic                  rd_en;
    logic                  ctrl_hit;
    logic [SLOTS-1:0]      sel;
    logic                  refresh_q;
    logic                  set_q;
    logic                  frz_q;
    logic [8*SLOTS-1:0]    hold_bits;
    logic [8*SLOTS-1:0]    live_bits;
    logic [7:0]            rd_mux;

    assign in_win    = &bus_addr[ADDR_W-1:4];
    assign nib       = bus_addr[3:0];
    assign wr_en     = bus_en && bus_we;
    assign rd_en     = bus_en && !bus_we;
    assign ctrl_hit  = in_win && (nib == 4'(CTRL_NIB));
    assign live_bits = live_i;
    assign hold_o    = rtc_time_t'(hold_bits);
    assign load_o    = wr_en && ctrl_hit && set_q && !bus_wdata[7];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            logic [7:0] byte_q;
            assign sel[g] = in_win && (nib == slot_nibble(g));
            // One holding byte: host write first, then the blockable refresh.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= RTC_RESET_BITS[8*g +: 8];
                else if (wr_en && sel[g])
                    byte_q <= bus_wdata;
                else if (refresh_q && !set_q && !frz_q)
                    byte_q <= live_bits[8*g +: 8];
            end
            assign hold_bits[8*g +: 8] = byte_q;
        end
    endgenerate

    // Delay the second pulse so the refresh copies the advanced counters.
    always_ff @(posedge clk) begin
        if (!rst_n)
            refresh_q <= 1'b0;
        else
            refresh_q <= refresh_i;
    end

    // Control bits: set (bit 7) and freeze (bit 6), written only by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= 1'b0;
            frz_q <= 1'b0;
        end else if (wr_en && ctrl_hit) begin
            set_q <= bus_wdata[7];
            frz_q <= bus_wdata[6];
        end
    end

    // Select the addressed holding byte; unmapped addresses give zero.
    always_comb begin
        rd_mux = 8'h00;
        for (int i = 0; i < SLOTS; i++)
            if (sel[i]) rd_mux = hold_bits[8*i +: 8];
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (rd_en)
            bus_rdata <= ctrl_hit ? {set_q, frz_q, 6'b0} : rd_mux;
    end

    // R8: while frozen and not written by the host, the holding bytes keep their value.
    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && !(wr_en && |sel)) |=> $stable(hold_bits));
    // R9: while the set bit is on, the refresh cannot move the holding bytes.
    a_r9_set_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_q && !(wr_en && |sel)) |=> $stable(hold_bits));
    // R9: a load leaves the set bit cleared.
    a_r9_load_clears_set: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !set_q);
    // R12: reads outside the clock bytes return zero.
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ctrl_hit && !(|sel)) |=> (bus_rdata == 8'h00));
    // R11: a host write to a slot lands even in a refresh cycle.
    a_r11_host_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[0]) |=> (hold_bits[7:0] == $past(bus_wdata)));
endmodule

// File: rtl/rtc_calendar_top.sv
// Module rtc_calendar_top
// Memory-mapped BCD calendar clock. It ties the one-second prescaler, the
// live counter chain and the host holding/control bytes together. A load
// restarts the prescaler. Assumes ref_tick is a one-cycle enable in clk domain.
module rtc_calendar_top
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DIV_COUNT = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic      sec_pulse;
    logic      load;
    rtc_time_t live;
    rtc_time_t hold;

    rtc_sec_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .restart_i  (load),
        .pulse_o    (sec_pulse)
    );

    rtc_time_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (sec_pulse),
        .load_i     (load),
        .load_val_i (hold),
        .time_o     (live)
    );

    rtc_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .refresh_i (sec_pulse),
        .live_i    (live),
        .hold_o    (hold),
        .load_o    (load)
    );
endmodule

// File: tb/rtc_calendar_top_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_top_tb_top;
    localparam int AW  = 15;
    localparam int DIV = 8;
    localparam logic [AW-1:0] A_CTRL = 15'h7FF8;
    localparam logic [AW-1:0] A_SEC  = 15'h7FFF;
    localparam logic [AW-1:0] A_MIN  = 15'h7FFE;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ref_tick;
    logic          bus_en;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_calendar_top #(.ADDR_W(AW), .DIV_COUNT(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // ---------------- reference model (binary arithmetic) ----------------
    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic logic [63:0] pack(input int c, input int y, input int mo,
        input int d, input int dw, input int h, input int mi, input int s);
        return {i2b(c), i2b(y), i2b(mo), i2b(d), i2b(dw), i2b(h), i2b(mi), i2b(s)};
    endfunction
    function automatic logic [63:0] adv(input logic [63:0] t, input int n);
        int c, y, mo, d, dw, h, mi, s;
        c = b2i(t[63:56]); y = b2i(t[55:48]); mo = b2i(t[47:40]); d = b2i(t[39:32]);
        dw = b2i(t[31:24]); h = b2i(t[23:16]); mi = b2i(t[15:8]); s = b2i(t[7:0]);
        for (int k = 0; k < n; k++) begin
            s++;
            if (s == 60) begin
                s = 0; mi++;
                if (mi == 60) begin
                    mi = 0; h++;
                    if (h == 24) begin
                        h = 0; dw = (dw == 7) ? 1 : dw + 1; d++;
                        if (d > mdays(mo, y)) begin
                            d = 1; mo++;
                            if (mo == 13) begin
                                mo = 1; y++;
                                if (y == 100) begin y = 0; c = (c + 1) % 100; end
                            end
                        end
                    end
                end
            end
        end
        return pack(c, y, mo, d, dw, h, mi, s);
    endfunction
    function automatic logic [AW-1:0] slot_addr(input int i);
        return (i == 7) ? 15'h7FF1 : AW'(15'h7FFF - i);
    endfunction

    // ---------------- bus tasks and checks ----------------
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask
    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask
    task automatic read_all(output logic [63:0] t);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            rd(slot_addr(i), b);
            t[8*i +: 8] = b;
        end
    endtask
    task automatic load_time(input logic [63:0] t, input int gap);
        wr(A_CTRL, 8'h80);
        for (int i = 0; i < 8; i++) wr(slot_addr(i), t[8*i +: 8]);
        repeat (gap) @(negedge clk);
        wr(A_CTRL, 8'h00);
    endtask
    // Wait k seconds after a load, freeze, read all bytes, unfreeze and compare.
    task automatic freeze_check(input string req, input logic [63:0] exp, input int k);
        logic [63:0] got;
        repeat (DIV * k) @(negedge clk);
        wr(A_CTRL, 8'h40);
        read_all(got);
        wr(A_CTRL, 8'h00);
        check(req, got, exp);
    endtask
    task automatic run_case(input string req, input logic [63:0] t, input int k);
        load_time(t, 0);
        freeze_check(req, adv(t, k), k);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [63:0] t, got;
        logic [7:0]  b;
        int c, y, mo, d, h, mi, s, k;
        rst_n = 1'b0; ref_tick = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        void'($urandom(32'd24681357));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, reference held low so nothing advances (R2)
        read_all(got);
        check("R1 reset time", got, 64'h20_00_01_01_01_00_00_00);
        rd(A_CTRL, b);
        check("R1 reset ctrl", {56'd0, b}, 64'd0);
        repeat (20) @(negedge clk);
        rd(A_SEC, b);
        check("R2 no ref pulses, no advance", {56'd0, b}, 64'd0);
        ref_tick = 1'b1;

        // R2/R7: first second exactly DIV pulses after load, refresh one edge later
        t = pack(20, 10, 6, 15, 3, 8, 30, 20);
        load_time(t, 0);
        repeat (6) @(negedge clk);
        rd(A_SEC, b);
        check("R2 before first tick", {56'd0, b}, {56'd0, t[7:0]});
        rd(A_SEC, b);
        check("R7 refreshed after first tick", {56'd0, b}, {56'd0, adv(t, 1) >> 0} & 64'hFF);

        // Directed calendar corners
        run_case("R3 second/minute/hour wrap", pack(20, 5, 3, 10, 2, 23, 59, 59), 1);
        run_case("R3 minute carry only", pack(20, 5, 3, 10, 2, 11, 59, 58), 3);
        run_case("R4 dow 7 to 1", pack(20, 5, 3, 12, 7, 23, 59, 59), 1);
        run_case("R5 leap Feb 28 to 29", pack(20, 24, 2, 28, 3, 23, 59, 59), 1);
        run_case("R5 leap Feb 29 to Mar 1", pack(20, 24, 2, 29, 4, 23, 59, 59), 1);
        run_case("R5 plain Feb 28 to Mar 1", pack(20, 23, 2, 28, 2, 23, 59, 59), 1);
        run_case("R5 year 00 is leap", pack(21, 0, 2, 28, 1, 23, 59, 59), 1);
        run_case("R5 Apr 30 to May 1", pack(20, 7, 4, 30, 5, 23, 59, 59), 1);
        run_case("R5 Jan 31 to Feb 1", pack(20, 7, 1, 31, 5, 23, 59, 59), 1);
        run_case("R6 Dec 31 year 99 to century", pack(19, 99, 12, 31, 5, 23, 59, 59), 2);
        run_case("R6 century 99 wraps", pack(99, 99, 12, 31, 6, 23, 59, 59), 1);

        // Constrained random calendar starts near rollovers
        for (int n = 0; n < 30; n++) begin
            c  = $urandom_range(19, 21);
            y  = ($urandom_range(0, 3) == 0) ? 99 : $urandom_range(0, 99);
            mo = ($urandom_range(0, 2) == 0) ? 12 : $urandom_range(1, 12);
            d  = ($urandom_range(0, 1) == 1) ? mdays(mo, y) : $urandom_range(1, mdays(mo, y));
            h  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
            mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
            s  = ($urandom_range(0, 1) == 1) ? $urandom_range(57, 59) : $urandom_range(0, 59);
            k  = $urandom_range(1, 3);
            run_case("R3 R5 R6 random", pack(c, y, mo, d, $urandom_range(1, 7), h, mi, s), k);
        end

        // R8: freeze holds the holding bytes while the counters run
        t = pack(20, 30, 8, 8, 4, 10, 10, 10);
        load_time(t, 0);
        wr(A_CTRL, 8'h40);
        repeat (20) @(negedge clk);
        rd(A_SEC, b);
        check("R8 frozen second", {56'd0, b}, {56'd0, t[7:0]});
        wr(A_CTRL, 8'h00);
        repeat (8) @(negedge clk);
        got = adv(t, 4);
        rd(A_SEC, b);
        check("R8 live after unfreeze", {56'd0, b}, {56'd0, got[7:0]});

        // R9: set bit blocks refresh, accepts writes, clearing loads
        t = pack(20, 40, 9, 9, 6, 9, 9, 9);
        load_time(t, 0);
        wr(A_CTRL, 8'h80);
        repeat (20) @(negedge clk);
        rd(A_SEC, b);
        check("R9 no refresh while set", {56'd0, b}, {56'd0, t[7:0]});
        wr(A_SEC, 8'h45);
        rd(A_SEC, b);
        check("R9 host write held", {56'd0, b}, 64'h45);
        wr(A_CTRL, 8'h00);
        t[7:0] = 8'h45;
        freeze_check("R9 load on clear", adv(t, 1), 1);

        // R10: load lands on the pulse edge (24 cycles after the previous load)
        load_time(pack(20, 1, 1, 1, 1, 0, 0, 0), 0);
        t = pack(20, 50, 5, 5, 5, 5, 5, 5);
        load_time(t, 4);
        freeze_check("R10 load beats tick", adv(t, 1), 1);

        // R11: host write of seconds on the refresh edge
        t = pack(20, 12, 3, 4, 5, 12, 34, 59);
        load_time(t, 0);
        repeat (7) @(negedge clk);
        wr(A_SEC, 8'h33);
        rd(A_SEC, b);
        check("R11 host second wins", {56'd0, b}, 64'h33);
        rd(A_MIN, b);
        check("R11 minute refreshed", {56'd0, b}, 64'h35);

        // R12: reserved and out-of-window bytes
        wr(15'h7FF3, 8'hAA);
        rd(15'h7FF3, b);
        check("R12 reserved reads zero", {56'd0, b}, 64'd0);
        rd(15'h0123, b);
        check("R12 outside window reads zero", {56'd0, b}, 64'd0);
        wr(A_CTRL, 8'h40);
        read_all(t);
        wr(15'h7FF5, 8'h11);
        wr(15'h7FF0, 8'h22);
        wr(15'h0001, 8'h33);
        read_all(got);
        check("R12 stray writes change nothing", got, t);
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, b);
        check("R12 ctrl readback", {56'd0, b}, 64'hC0);
        wr(A_CTRL, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule